// File: doc/BRIEF.md
# Speaker Gate Control Port

This block is a byte-wide, I/O-mapped control and status register for the tone channel of an external interval timer. When software writes the register, two stored bits are updated. One drives the gate input of timer channel 2, which starts or holds the tone counter. The other drives the enable that lets speaker data through. The timer itself and the audio path are outside this block.

When software reads the register, it gets back the two stored control bits. The same byte also carries the output of timer channel 2, sampled through a short synchroniser, and a refresh indicator. The refresh indicator flips on every read access, so a polling loop sees a changing bit. Any read bit without a function returns zero.

The bus is a simple single-cycle register port with a chip select, a write strobe, a read strobe and 8-bit data in each direction. Read data is registered: it appears in the cycle after the read strobe and stays there until the next read.

Top module: `spk_gate_port`

## Requirements
- R1: A write (`cs_i` and `wr_i` high at a clock edge) loads `wdata_i` bit 0 into the channel-2 gate, and `tmr2_gate_o` shows the new value from the next cycle on.
- R2: A write loads `wdata_i` bit 1 into the speaker data enable, and `spk_en_o` shows the new value from the next cycle on.
- R3: A read (`cs_i` and `rd_i` high) returns the gate in `rdata_o` bit 0 and the speaker enable in bit 1, as they stood before the edge. A write in the same cycle as a read is therefore not yet visible in that read.
- R4: Read bit 5 carries `tmr2_out_i` after SYNC_STAGES register stages. A level held for at least SYNC_STAGES+1 cycles before the read strobe is the level returned.
- R5: Read bit 4 is a refresh indicator that flips once per read access. The first read after reset returns 1, the second returns 0, and so on alternately.
- R6: Read bits 2, 3, 6 and 7 are always zero.
- R7: Synchronous reset clears the gate, the speaker enable, the refresh indicator and `rdata_o`.
- R8: A strobe with `cs_i` low has no effect, and a write does not flip the refresh indicator.
- R9: `rdata_o` changes only in the cycle after a read strobe and holds its value between reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_i | input | 1 | Chip select for this port |
| wr_i | input | 1 | Write strobe, single cycle |
| rd_i | input | 1 | Read strobe, single cycle |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| tmr2_out_i | input | 1 | Output of timer channel 2 |
| tmr2_gate_o | output | 1 | Gate of timer channel 2 |
| spk_en_o | output | 1 | Speaker data enable |

## Verification
The refresh bit is the hardest behaviour to pin down from the ports. Its value depends on how many real reads came earlier. It must not move on writes, on strobes with the select low, or on idle cycles, and a single missed or extra toggle only shows up in a later read. The stimulus therefore mixes gated-off strobes and writes between reads. A reference model in the bench counts only genuine reads, and each read is compared in full against a scoreboard queue. The bench also issues a write and a read in the same cycle, to show that a read returns the control bits as they stood before that write.

// File: rtl/spk_pkg.sv
package spk_pkg;
  localparam int DATA_W   = 8;
  localparam int BIT_GATE = 0;
  localparam int BIT_SPK  = 1;
  localparam int BIT_REF  = 4;
  localparam int BIT_TMR  = 5;

  typedef struct packed {
    logic spk;
    logic gate;
  } ctrl_t;
endpackage

// File: rtl/spk_ctrl_reg.sv
module spk_ctrl_reg
  import spk_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  wr_hit,
  input  logic  gate_d,
  input  logic  spk_d,
  output ctrl_t ctrl_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (wr_hit) begin
      ctrl_q.gate <= gate_d;
      ctrl_q.spk  <= spk_d;
    end
  end
endmodule

// File: rtl/spk_refresh_tgl.sv
module spk_refresh_tgl (
  input  logic clk,
  input  logic rst,
  input  logic rd_hit,
  output logic ref_nxt
);
  logic ref_q;

  assign ref_nxt = ~ref_q;

  always_ff @(posedge clk) begin
    if (rst)         ref_q <= 1'b0;
    else if (rd_hit) ref_q <= ref_nxt;
  end
endmodule

// File: rtl/spk_sync.sv
module spk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/spk_rd_mux.sv
module spk_rd_mux
  import spk_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_hit,
  input  ctrl_t             ctrl,
  input  logic              ref_bit,
  input  logic              tmr_bit,
  output logic [DATA_W-1:0] rdata_q
);
  logic [DATA_W-1:0] rd_word;

  always_comb begin
    rd_word           = '0;
    rd_word[BIT_GATE] = ctrl.gate;
    rd_word[BIT_SPK]  = ctrl.spk;
    rd_word[BIT_REF]  = ref_bit;
    rd_word[BIT_TMR]  = tmr_bit;
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (rd_hit) rdata_q <= rd_word;
  end
endmodule

// File: rtl/spk_gate_port.sv
module spk_gate_port
  import spk_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              tmr2_out_i,
  output logic              tmr2_gate_o,
  output logic              spk_en_o
);
  logic  wr_hit, rd_hit, ref_nxt, tmr_s;
  ctrl_t ctrl_q;
  logic  unused_wbits;

  assign wr_hit       = cs_i & wr_i;
  assign rd_hit       = cs_i & rd_i;
  assign unused_wbits = ^wdata_i[DATA_W-1:2];

  spk_ctrl_reg u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .wr_hit (wr_hit),
    .gate_d (wdata_i[BIT_GATE]),
    .spk_d  (wdata_i[BIT_SPK]),
    .ctrl_q (ctrl_q)
  );

  spk_refresh_tgl u_ref (
    .clk     (clk),
    .rst     (rst),
    .rd_hit  (rd_hit),
    .ref_nxt (ref_nxt)
  );

  spk_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (tmr2_out_i),
    .dout (tmr_s)
  );

  spk_rd_mux u_mux (
    .clk     (clk),
    .rst     (rst),
    .rd_hit  (rd_hit),
    .ctrl    (ctrl_q),
    .ref_bit (ref_nxt),
    .tmr_bit (tmr_s),
    .rdata_q (rdata_o)
  );

  assign tmr2_gate_o = ctrl_q.gate;
  assign spk_en_o    = ctrl_q.spk;
endmodule

// File: rtl/spk_gate_port_chk.sv
module spk_gate_port_chk (
  input logic       clk,
  input logic       rst,
  input logic       cs_i,
  input logic       wr_i,
  input logic       rd_i,
  input logic [7:0] wdata_i,
  input logic [7:0] rdata_o,
  input logic       tmr2_gate_o,
  input logic       spk_en_o
);
  AST_WRITE_GATE: assert property (@(posedge clk) disable iff (rst)
    (cs_i && wr_i) |=> (tmr2_gate_o == $past(wdata_i[0]))); // R1
  AST_WRITE_SPK: assert property (@(posedge clk) disable iff (rst)
    (cs_i && wr_i) |=> (spk_en_o == $past(wdata_i[1]))); // R2
  AST_READ_CTRL: assert property (@(posedge clk) disable iff (rst)
    (cs_i && rd_i) |=> (rdata_o[1:0] == {$past(spk_en_o), $past(tmr2_gate_o)})); // R3
  AST_REFRESH_FLIP: assert property (@(posedge clk) disable iff (rst)
    (cs_i && rd_i) |=> (rdata_o[4] != $past(rdata_o[4]))); // R5
  AST_ZERO_BITS: assert property (@(posedge clk) disable iff (rst)
    (rdata_o[7:6] == 2'b00) && (rdata_o[3:2] == 2'b00)); // R6
  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(cs_i && wr_i) |=> ($stable(tmr2_gate_o) && $stable(spk_en_o))); // R8
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(cs_i && rd_i) |=> $stable(rdata_o)); // R9
endmodule

bind spk_gate_port spk_gate_port_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .cs_i        (cs_i),
  .wr_i        (wr_i),
  .rd_i        (rd_i),
  .wdata_i     (wdata_i),
  .rdata_o     (rdata_o),
  .tmr2_gate_o (tmr2_gate_o),
  .spk_en_o    (spk_en_o)
);

// File: tb/spk_gate_port_tb.sv
module spk_gate_port_tb;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs = 1'b0, wr = 1'b0, rd = 1'b0, tmr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       gate, spk;

  int n_chk = 0;
  int n_bad = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       m_gate = 0, m_spk = 0, m_ref = 0;
  logic       rd_seen = 0;

  always #(CLK_P/2) clk = ~clk;

  spk_gate_port u_dut (
    .clk(clk), .rst(rst), .cs_i(cs), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .tmr2_out_i(tmr),
    .tmr2_gate_o(gate), .spk_en_o(spk)
  );

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  always @(posedge clk) rd_seen <= cs && rd && !rst;

  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        check("R9 unexpected read", rdata, 8'hxx);
      end else begin
        check(tag_q.pop_front(), rdata, exp_q.pop_front());
      end
    end
  end

  task automatic do_write(logic [7:0] d);
    @(negedge clk);
    cs = 1; wr = 1; wdata = d;
    @(negedge clk);
    cs = 0; wr = 0;
    m_gate = d[0]; m_spk = d[1];
  endtask

  task automatic do_read(string tag);
    @(negedge clk);
    cs = 1; rd = 1;
    m_ref = ~m_ref;
    exp_q.push_back({2'b00, tmr, m_ref, 2'b00, m_spk, m_gate});
    tag_q.push_back(tag);
    @(negedge clk);
    cs = 0; rd = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle(3);
    rst = 0;
    idle(1);
    check("R7 reset gate", {7'b0, gate}, 8'h00);
    check("R7 reset spk", {7'b0, spk}, 8'h00);
    check("R7 reset rdata", rdata, 8'h00);

    do_read("R5 first read after reset");
    do_read("R5 second read");

    do_write(8'h01);
    check("R1 gate set", {7'b0, gate}, 8'h01);
    check("R2 spk clear", {7'b0, spk}, 8'h00);
    do_read("R3 gate only");

    do_write(8'hFE);
    check("R1 gate clear", {7'b0, gate}, 8'h00);
    check("R2 spk set", {7'b0, spk}, 8'h01);
    do_read("R6 unused bits zero after FE");

    tmr = 1'b1;
    idle(4);
    do_read("R4 timer high");
    tmr = 1'b0;
    idle(4);
    do_read("R4 timer low");

    // R8: strobes with select low
    @(negedge clk); wr = 1; rd = 1; wdata = 8'h01;
    @(negedge clk); wr = 0; rd = 0;
    check("R8 gate unchanged", {7'b0, gate}, 8'h00);
    check("R8 spk unchanged", {7'b0, spk}, 8'h01);
    check("R9 rdata held", rdata, {2'b00, 1'b0, m_ref, 2'b00, m_spk, m_gate});
    do_write(8'h03);
    do_write(8'h00);
    do_read("R8 refresh unmoved by writes");

    // R3: write and read in the same cycle
    @(negedge clk);
    cs = 1; wr = 1; rd = 1; wdata = 8'h03;
    m_ref = ~m_ref;
    exp_q.push_back({2'b00, tmr, m_ref, 2'b00, m_spk, m_gate});
    tag_q.push_back("R3 read sees pre-write value");
    @(negedge clk);
    cs = 0; wr = 0; rd = 0;
    m_gate = 1; m_spk = 1;
    do_read("R3 read sees written value");
    idle(5);
    check("R9 rdata held idle", rdata, {2'b00, 1'b0, m_ref, 2'b00, m_spk, m_gate});

    rst = 1;
    idle(2);
    rst = 0;
    m_gate = 0; m_spk = 0; m_ref = 0;
    idle(1);
    check("R7 re-reset rdata", rdata, 8'h00);
    check("R7 re-reset gate", {6'b0, spk, gate}, 8'h00);
    do_read("R7 refresh cleared by reset");

    idle(3);
    if (exp_q.size() != 0) begin
      n_chk++; n_bad++;
      $display("FAIL R9 pending reads: actual %0d expected 0", exp_q.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule